// File: doc/BRIEF.md
# Decimal-Step PWM Generator

This block turns a fast reference clock into a fixed-frequency pulse-width-modulated output. The duty cycle is set in whole percent. A chain of decade (BCD) counter stages runs through 00 to 99 and wraps, so one output period always lasts exactly 100 reference ticks. With a 2 MHz reference the output runs at 20 kHz. The requested duty is supplied as two packed BCD digits. It is compared digit by digit against the running count, with no binary conversion anywhere in the path.

At the tick that closes a period, the block captures the requested duty into a holding register. The value it captures has first passed through a clamp: a request of zero becomes one percent, and any request with a digit above nine becomes 99 percent. The output therefore always toggles inside every period. The output flip-flop goes high as each period opens and goes low once the requested number of ticks has passed. A one-tick strobe marks the opening tick of each period. After a synchronous reset the output stays low until the first period opens, 100 ticks after reset is released.

The duty input is a level that is sampled once per period, so it carries no handshake and can never stall. The number of BCD digits is a parameter: the period is 10 to the power of the digit count.

Top module: `bcd_pwm_gen`

## Requirements
- R1: While `rst` is high, `pwm_out` and `period_stb` are low on the next clock. After release, `pwm_out` stays low until the first `period_stb`, which arrives on the 100th rising edge after the last reset edge.
- R2: `period_stb` is high for exactly one tick, and successive strobes are exactly 100 ticks apart.
- R3: `pwm_out` is high in every tick in which `period_stb` is high, and it rises only in such a tick.
- R4: For a duty value N from 01 to 99 (tens digit in bits 7:4, units digit in bits 3:0), `pwm_out` is high for exactly N consecutive ticks per period, starting at the strobe tick.
- R5: A duty value of 00 gives a high time of 1 tick.
- R6: A duty value with either digit in the range A to F gives a high time of 99 ticks.
- R7: Changing `duty_bcd` in the middle of a period has no effect on the high time of that period.
- R8: The duty value used for a period is the value present on `duty_bcd` in the tick just before that period's strobe. A change made during the strobe tick first takes effect in the following period.
- R9: `pwm_out` is low in the tick just before every strobe, so the output is never constant over a whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 100 ticks per output period |
| rst | input | 1 | Synchronous reset, active high |
| duty_bcd | input | 4*DIGITS | Requested duty in packed BCD, most significant digit in the top nibble |
| pwm_out | output | 1 | PWM output level |
| period_stb | output | 1 | One-tick pulse on the opening tick of each period |

## Verification
The bench builds the block with the default two digits. This gives a 100-tick period, so the whole duty range and both clamp directions can be exercised within a few hundred periods. That includes both ends of the range, 01 and 99, where the output is high for one tick or low for one tick. With two digits, each digit can be made invalid on its own: the bench drives invalid values in the tens nibble, the units nibble, and both. The short period also makes it practical to time setpoint changes exactly against the latch tick: the tick just before the strobe, the strobe tick itself, and the middle of a period.

// File: rtl/bcd_pwm_pkg.sv
package bcd_pwm_pkg;

  typedef logic [3:0] bcd_digit_t;

  localparam bcd_digit_t BCD_NINE = 4'd9;
  localparam bcd_digit_t BCD_ZERO = 4'd0;

  // A digit is legal BCD when it does not exceed nine.
  function automatic logic bcd_digit_legal(input bcd_digit_t d);
    return d <= BCD_NINE;
  endfunction

  // Next value of a single decade stage when it is enabled.
  function automatic bcd_digit_t bcd_digit_step(input bcd_digit_t d);
    return (d == BCD_NINE) ? BCD_ZERO : bcd_digit_t'(d + 4'd1);
  endfunction

endpackage

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage
  import bcd_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       carry_in,
  output bcd_digit_t q,
  output bcd_digit_t q_nxt,
  output logic       carry_out
);

  // This stage advances only when every lower stage is at nine.
  assign q_nxt     = carry_in ? bcd_digit_step(q) : q;
  assign carry_out = carry_in & (q == BCD_NINE);

  always_ff @(posedge clk) begin
    if (rst) q <= BCD_ZERO;
    else     q <= q_nxt;
  end

endmodule

// File: rtl/bcd_setpoint_clamp.sv
module bcd_setpoint_clamp
  import bcd_pwm_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
)(
  input  logic [W-1:0] raw,
  output logic [W-1:0] clamped
);

  logic [DIGITS-1:0] bad;
  logic [DIGITS-1:0] zero;
  logic [W-1:0]      all_nines;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign bad[g]             = !bcd_digit_legal(raw[4*g +: 4]);
    assign zero[g]            = (raw[4*g +: 4] == BCD_ZERO);
    assign all_nines[4*g +: 4] = BCD_NINE;
  end

  localparam logic [W-1:0] ONE = W'(1);

  // An illegal digit anywhere wins over the zero case.
  always_comb begin
    if (|bad)       clamped = all_nines;
    else if (&zero) clamped = ONE;
    else            clamped = raw;
  end

endmodule

// File: rtl/bcd_match.sv
module bcd_match
  import bcd_pwm_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
)(
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);

  logic [DIGITS-1:0] dig_eq;

  for (genvar g = 0; g < DIGITS; g++) begin : g_cmp
    assign dig_eq[g] = (bcd_digit_t'(a[4*g +: 4]) == bcd_digit_t'(b[4*g +: 4]));
  end

  assign eq = &dig_eq;

endmodule

// File: rtl/bcd_pwm_gen.sv
module bcd_pwm_gen
  import bcd_pwm_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] duty_bcd,
  output logic         pwm_out,
  output logic         period_stb
);

  localparam logic [W-1:0] DUTY_MIN = W'(1);

  logic [DIGITS:0] carry;
  logic [W-1:0]    cnt_q;
  logic [W-1:0]    cnt_nxt;
  logic [W-1:0]    duty_safe;
  logic [W-1:0]    duty_hold;
  logic            hit_end;
  logic            wrap_now;
  logic            pwm_q;
  logic            stb_q;

  assign carry[0] = 1'b1;

  // Decade chain: each stage is enabled by the carry of the stages below it.
  for (genvar g = 0; g < DIGITS; g++) begin : g_stage
    bcd_decade_stage u_stage (
      .clk      (clk),
      .rst      (rst),
      .carry_in (carry[g]),
      .q        (cnt_q[4*g +: 4]),
      .q_nxt    (cnt_nxt[4*g +: 4]),
      .carry_out(carry[g+1])
    );
  end

  // A carry out of the top stage means every digit is nine: the period ends.
  assign wrap_now = carry[DIGITS];

  bcd_setpoint_clamp #(.DIGITS(DIGITS)) u_clamp (
    .raw    (duty_bcd),
    .clamped(duty_safe)
  );

  bcd_match #(.DIGITS(DIGITS)) u_match (
    .a (cnt_nxt),
    .b (duty_hold),
    .eq(hit_end)
  );

  // The duty setting is taken only at the period boundary.
  always_ff @(posedge clk) begin
    if (rst)           duty_hold <= DUTY_MIN;
    else if (wrap_now) duty_hold <= duty_safe;
  end

  // Set as a period opens, cleared when the next count equals the held duty.
  always_ff @(posedge clk) begin
    if (rst)           pwm_q <= 1'b0;
    else if (wrap_now) pwm_q <= 1'b1;
    else if (hit_end)  pwm_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= wrap_now;
  end

  assign pwm_out    = pwm_q;
  assign period_stb = stb_q;

endmodule

// File: rtl/bcd_pwm_gen_chk.sv
module bcd_pwm_gen_chk #(
  parameter int DIGITS = 2
)(
  input logic clk,
  input logic rst,
  input logic pwm_out,
  input logic period_stb
);

  localparam int PERIOD = 10 ** DIGITS;
  localparam int KW     = $clog2(PERIOD);
  localparam logic [KW-1:0] K_LAST = KW'(PERIOD - 1);

  // Free-running tick count since reset, wrapping once per expected period.
  logic [KW-1:0] k;
  logic          started;

  always_ff @(posedge clk) begin
    if (rst) begin
      k       <= '0;
      started <= 1'b0;
    end else begin
      k       <= (k == K_LAST) ? '0 : k + 1'b1;
      started <= started | (k == K_LAST);
    end
  end

  // R1: reset forces both outputs low.
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!pwm_out && !period_stb));

  // R1: output low until the first period opens.
  a_r1_quiet_until_start: assert property (@(posedge clk) disable iff (rst)
    !started |-> !pwm_out);

  // R2: strobe only on the expected ticks.
  a_r2_stb_on_grid: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> (started && k == '0));

  // R2: strobe on every expected tick.
  a_r2_stb_every_period: assert property (@(posedge clk) disable iff (rst)
    (started && k == '0) |-> period_stb);

  // R2: strobe lasts one tick.
  a_r2_stb_single: assert property (@(posedge clk) disable iff (rst)
    period_stb |=> !period_stb);

  // R3: output high during the strobe tick.
  a_r3_high_on_stb: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> pwm_out);

  // R3: output rises only with the strobe.
  a_r3_rise_only_on_stb: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> period_stb);

  // R9: output low in the tick before each strobe.
  a_r9_low_before_stb: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> !$past(pwm_out));

endmodule

bind bcd_pwm_gen bcd_pwm_gen_chk #(.DIGITS(DIGITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwm_out   (pwm_out),
  .period_stb(period_stb)
);

// File: tb/tb_bcd_pwm_gen.sv
module tb_bcd_pwm_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DIGITS     = 2;
  localparam int PERIOD     = 100;
  localparam int NVEC       = 12;

  // {duty input (BCD), expected high ticks (binary)}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h50, 8'd50}, {8'h01, 8'd1},  {8'h99, 8'd99}, {8'h00, 8'd1},
    {8'h37, 8'd37}, {8'h10, 8'd10}, {8'h09, 8'd9},  {8'h9A, 8'd99},
    {8'hA0, 8'd99}, {8'hFF, 8'd99}, {8'h1F, 8'd99}, {8'h42, 8'd42}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] duty_bcd;
  logic       pwm_out;
  logic       period_stb;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_pwm_gen #(.DIGITS(DIGITS)) dut (
    .clk       (clk),
    .rst       (rst),
    .duty_bcd  (duty_bcd),
    .pwm_out   (pwm_out),
    .period_stb(period_stb)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Entered at the negedge of a strobe tick. Samples one whole period and
  // returns at the negedge of the next strobe tick. Optionally changes duty
  // at sample index chg_at.
  task automatic run_period(output int hi, output logic first_hi, output logic stray_stb,
                            input int chg_at, input logic [7:0] chg_val);
    hi = 0;
    stray_stb = 1'b0;
    first_hi = pwm_out;
    for (int i = 0; i < PERIOD; i++) begin
      if (pwm_out) hi++;
      if (i > 0 && period_stb) stray_stb = 1'b1;
      if (i == chg_at) duty_bcd = chg_val;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end

  initial begin
    int   hi;
    int   n;
    logic fh;
    logic st;
    logic seen_hi;

    rst = 1'b1;
    duty_bcd = 8'h50;
    repeat (3) @(negedge clk);
    check(!pwm_out && !period_stb, "R1 reset outputs", int'({pwm_out, period_stb}), 0);

    // R1: first strobe 100 ticks after release, output low until then
    rst = 1'b0;
    n = 0;
    seen_hi = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (!period_stb && pwm_out) seen_hi = 1'b1;
    end while (!period_stb && n < 300);
    check(n == PERIOD, "R1 first strobe delay", n, PERIOD);
    check(!seen_hi, "R1 low before first period", int'(seen_hi), 0);

    // Vector walk: set duty during a period, measure the next one
    for (int v = 0; v < NVEC; v++) begin
      duty_bcd = VEC[v][15:8];
      run_period(hi, fh, st, -1, 8'h00);
      check(period_stb, "R2 strobe spacing", int'(period_stb), 1);
      run_period(hi, fh, st, -1, 8'h00);
      check(fh, "R3 high on strobe tick", int'(fh), 1);
      check(!st, "R2 single strobe per period", int'(st), 0);
      check(period_stb, "R2 strobe spacing", int'(period_stb), 1);
      if (VEC[v][15:8] == 8'h00)
        check(hi == int'(VEC[v][7:0]), "R5 zero clamps to one", hi, int'(VEC[v][7:0]));
      else if (VEC[v][15:12] > 4'd9 || VEC[v][11:8] > 4'd9)
        check(hi == int'(VEC[v][7:0]), "R6 illegal digit clamps to 99", hi, int'(VEC[v][7:0]));
      else
        check(hi == int'(VEC[v][7:0]), "R4 high time", hi, int'(VEC[v][7:0]));
      if (VEC[v][15:8] == 8'h99)
        check(hi < PERIOD, "R9 low tick per period", hi, PERIOD - 1);
    end

    // R7: mid-period change does not affect the running period
    duty_bcd = 8'h20;
    run_period(hi, fh, st, -1, 8'h00);
    run_period(hi, fh, st, 5, 8'h80);
    check(hi == 20, "R7 mid-period change ignored", hi, 20);
    run_period(hi, fh, st, -1, 8'h00);
    check(hi == 80, "R7 change applies next period", hi, 80);

    // R8: change in the last tick applies; change on strobe tick waits
    run_period(hi, fh, st, PERIOD - 1, 8'h65);
    check(hi == 80, "R8 last-tick change not in current period", hi, 80);
    run_period(hi, fh, st, 0, 8'h12);
    check(hi == 65, "R8 last-tick value latched", hi, 65);
    run_period(hi, fh, st, -1, 8'h00);
    check(hi == 12, "R8 strobe-tick change deferred", hi, 12);

    // R1: reset in mid-period while output is high
    duty_bcd = 8'h90;
    run_period(hi, fh, st, -1, 8'h00);
    repeat (10) @(negedge clk);
    check(pwm_out, "R4 high before reset", int'(pwm_out), 1);
    rst = 1'b1;
    @(negedge clk);
    check(!pwm_out && !period_stb, "R1 mid-period reset", int'({pwm_out, period_stb}), 0);
    rst = 1'b0;
    n = 0;
    seen_hi = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (!period_stb && pwm_out) seen_hi = 1'b1;
    end while (!period_stb && n < 300);
    check(n == PERIOD, "R1 restart strobe delay", n, PERIOD);
    check(!seen_hi, "R1 low after restart", int'(seen_hi), 0);
    run_period(hi, fh, st, -1, 8'h00);
    check(hi == 90, "R4 high time after restart", hi, 90);

    finish_up();
  end

endmodule